// File: doc/BRIEF.md
# Short-Circuit Event Window Detector

This block separates a real output short from an ordinary overload in a voltage-mode PWM controller. In a short, the current limit trips early in the switching period, so the on-time collapses. In an ordinary overload, the current limit trips late. On each oscillator ramp cycle, the block checks whether the overcurrent flag fired before the ramp crossed a programmable duty threshold. If it did, that cycle is recorded as one short-circuit event.

The block keeps a sliding history of the most recent oscillator cycles. When enough of those cycles hold an event, it raises a single-clock shutdown request to the fault sequencer. The duty threshold is set by a setpoint code, and a code of zero turns detection off. Detection is active only after soft-start has completed. The history empties when soft-start is not complete and again each time a request fires.

Top module: `sc_short_detect`

## Requirements
- R1: The threshold is floor(code * RAMP_MAX / 2^CODE_W), so the full code range spans setpoints from 0 up to twice the midscale value, and midscale gives half of the maximum-duty ramp count. A cycle becomes an event when `oc_flag` is high on a clock where `ramp` is below the threshold and `ramp` has not reached the threshold earlier in that cycle.
- R2: An overcurrent that arrives on or after the first clock of the cycle at which `ramp` >= threshold does not create an event.
- R3: A cycle contributes at most one event, no matter how many clocks of overcurrent it contains.
- R4: On a `cyc_start` clock with `ss_done` high, the event flag of the cycle just finished enters the history. If the number of events among the last WIN_LEN (32) finished cycles then reaches EVT_LIMIT (8), `sd_req` is high for exactly the following clock.
- R5: While `sc_code` is zero, no event is recorded and `sd_req` never asserts.
- R6: While `ss_done` is low, no event is recorded and the history is empty. Events from before a soft-start restart never count afterwards.
- R7: The history clears when `sd_req` fires, so a further request needs EVT_LIMIT fresh events.
- R8: An event that is more than WIN_LEN finished cycles old no longer counts.
- R9: After reset `sd_req` is low and the history is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_start | input | 1 | One-clock strobe on the first clock of each oscillator ramp cycle |
| ramp | input | RAMP_W | Ramp count for the current clock, 0 at cycle start |
| sc_code | input | CODE_W | Short-circuit duty setpoint code; zero disables detection |
| oc_flag | input | 1 | Cycle-by-cycle overcurrent comparator output |
| ss_done | input | 1 | High once soft-start has completed |
| sd_req | output | 1 | One-clock shutdown request |

## Verification
The bench builds the block with RAMP_W=6, RAMP_MAX=40 and CODE_W=4, and keeps the default 32-cycle window and limit of 8. With these values a ramp cycle lasts only 48 clocks and midscale code 8 places the threshold at count 20. This makes runs of 30 to 40 ramp cycles affordable, so the bench can test window expiry exactly one cycle past its edge and back-to-back requests. It can also check the overcurrent position one count before the threshold and exactly at it.

// File: rtl/sc_pkg.sv
package sc_pkg;

   // Selects how the window population is maintained.
   typedef enum logic {
      CNT_RUNNING = 1'b0,   // incremental add/subtract counter
      CNT_REDUCE  = 1'b1    // full reduction of the history each shift
   } cnt_style_e;

   localparam int unsigned MAX_WIN = 64;

   // Population count of a history vector of at most MAX_WIN bits.
   function automatic int unsigned ones64(input logic [MAX_WIN-1:0] v);
      int unsigned n;
      n = 0;
      for (int i = 0; i < MAX_WIN; i++) begin
         n += int'(v[i]);
      end
      return n;
   endfunction

endpackage

// File: rtl/sc_thresh_scale.sv
module sc_thresh_scale #(
   parameter int unsigned RAMP_W   = 10,
   parameter int unsigned CODE_W   = 8,
   parameter int unsigned RAMP_MAX = 1000
) (
   input  logic [CODE_W-1:0] sp_code,
   output logic [RAMP_W-1:0] thr,
   output logic              code_on
);

   localparam int unsigned PROD_W = RAMP_W + CODE_W;

   initial begin
      assert (RAMP_MAX < (1 << RAMP_W))
         else $error("sc_thresh_scale: RAMP_MAX does not fit RAMP_W");
      assert (CODE_W >= 2)
         else $error("sc_thresh_scale: CODE_W too small");
   end

   // Full-scale code equals twice the midscale setpoint; threshold is the
   // code fraction of the maximum-duty ramp count (R1).
   assign thr     = RAMP_W'((PROD_W'(sp_code) * PROD_W'(RAMP_MAX)) >> CODE_W);
   assign code_on = |sp_code;

endmodule

// File: rtl/sc_cycle_track.sv
module sc_cycle_track #(
   parameter int unsigned RAMP_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cyc_start,
   input  logic [RAMP_W-1:0] ramp,
   input  logic [RAMP_W-1:0] thr,
   input  logic              oc,
   input  logic              en,
   output logic              event_o
);

   logic crossed_q, crossed_base, crossed_d;
   logic event_q, event_base, event_d;
   logic cross_now, evt_now;

   // A new cycle forgets the previous cycle's crossing and event.
   assign crossed_base = cyc_start ? 1'b0 : crossed_q;
   assign event_base   = cyc_start ? 1'b0 : event_q;

   assign cross_now = (ramp >= thr);
   assign crossed_d = crossed_base | cross_now;
   assign evt_now   = oc & ~crossed_d;
   assign event_d   = en ? (event_base | evt_now) : 1'b0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         crossed_q <= 1'b0;
         event_q   <= 1'b0;
      end else begin
         crossed_q <= crossed_d;
         event_q   <= event_d;
      end
   end

   assign event_o = event_q;

   // R1: early overcurrent while enabled marks the cycle.
   p_early_oc_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (en && oc && (ramp < thr) && (cyc_start || !crossed_q)) |=> event_q);

   // R2: once crossed, a later overcurrent cannot create the event.
   p_late_oc_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (crossed_q && !cyc_start && !event_q) |=> !event_q);

   // R3: an event stays a single flag until the cycle ends.
   p_one_event_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (event_q && !cyc_start && en) |=> event_q);

   // R5/R6: nothing is recorded while disabled.
   p_disabled_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> !event_q);

endmodule

// File: rtl/sc_event_window.sv
module sc_event_window
   import sc_pkg::*;
#(
   parameter int unsigned WIN_LEN   = 32,
   parameter int unsigned EVT_LIMIT = 8,
   parameter cnt_style_e  CNT_STYLE = CNT_RUNNING
) (
   input  logic clk,
   input  logic rst_n,
   input  logic shift_i,
   input  logic clear_i,
   input  logic bit_i,
   output logic req_o
);

   localparam int unsigned CNT_W = $clog2(WIN_LEN + 1);

   initial begin
      assert (WIN_LEN >= 2 && WIN_LEN <= MAX_WIN)
         else $error("sc_event_window: WIN_LEN out of range");
      assert (EVT_LIMIT >= 2 && EVT_LIMIT <= WIN_LEN)
         else $error("sc_event_window: EVT_LIMIT out of range");
   end

   logic [WIN_LEN-1:0] win_q, win_shifted;
   logic [CNT_W-1:0]   hist_cnt, next_cnt;
   logic               fire, req_q;

   assign win_shifted = {win_q[WIN_LEN-2:0], bit_i};

   generate
      if (CNT_STYLE == CNT_RUNNING) begin : g_run
         logic [CNT_W-1:0] cnt_q;

         assign next_cnt = cnt_q + CNT_W'(bit_i) - CNT_W'(win_q[WIN_LEN-1]);
         assign hist_cnt = cnt_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q <= '0;
            end else if (clear_i || fire) begin
               cnt_q <= '0;
            end else if (shift_i) begin
               cnt_q <= next_cnt;
            end
         end

         // R8: running count matches the history it summarises.
         p_cnt_track_r8: assert property (@(posedge clk) disable iff (!rst_n)
            hist_cnt == CNT_W'(ones64(MAX_WIN'(win_q))));
      end else begin : g_reduce
         assign hist_cnt = CNT_W'(ones64(MAX_WIN'(win_q)));
         assign next_cnt = CNT_W'(ones64(MAX_WIN'(win_shifted)));
      end
   endgenerate

   assign fire = shift_i & ~clear_i & (next_cnt >= CNT_W'(EVT_LIMIT));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         win_q <= '0;
         req_q <= 1'b0;
      end else begin
         req_q <= fire;
         if (clear_i || fire) begin
            win_q <= '0;
         end else if (shift_i) begin
            win_q <= win_shifted;
         end
      end
   end

   assign req_o = req_q;

   // R4: the request is a single-clock pulse.
   p_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
      req_q |=> !req_q);

   // R6: history is empty after a clock with soft-start incomplete.
   p_soft_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      clear_i |=> (hist_cnt == '0));

   // R7: the stored count always stays below the limit.
   p_below_limit_r7: assert property (@(posedge clk) disable iff (!rst_n)
      hist_cnt < CNT_W'(EVT_LIMIT));

   // R8: count never exceeds the window length.
   p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
      hist_cnt <= CNT_W'(WIN_LEN));

endmodule

// File: rtl/sc_short_detect.sv
module sc_short_detect
   import sc_pkg::*;
#(
   parameter int unsigned RAMP_W    = 10,
   parameter int unsigned CODE_W    = 8,
   parameter int unsigned RAMP_MAX  = 1000,
   parameter int unsigned WIN_LEN   = 32,
   parameter int unsigned EVT_LIMIT = 8,
   parameter cnt_style_e  CNT_STYLE = CNT_RUNNING
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cyc_start,
   input  logic [RAMP_W-1:0] ramp,
   input  logic [CODE_W-1:0] sc_code,
   input  logic              oc_flag,
   input  logic              ss_done,
   output logic              sd_req
);

   logic [RAMP_W-1:0] thr;
   logic              code_on;
   logic              det_en;
   logic              cyc_event;

   sc_thresh_scale #(
      .RAMP_W   (RAMP_W),
      .CODE_W   (CODE_W),
      .RAMP_MAX (RAMP_MAX)
   ) i_scale (
      .sp_code (sc_code),
      .thr     (thr),
      .code_on (code_on)
   );

   assign det_en = ss_done & code_on;

   sc_cycle_track #(
      .RAMP_W (RAMP_W)
   ) i_track (
      .clk       (clk),
      .rst_n     (rst_n),
      .cyc_start (cyc_start),
      .ramp      (ramp),
      .thr       (thr),
      .oc        (oc_flag),
      .en        (det_en),
      .event_o   (cyc_event)
   );

   sc_event_window #(
      .WIN_LEN   (WIN_LEN),
      .EVT_LIMIT (EVT_LIMIT),
      .CNT_STYLE (CNT_STYLE)
   ) i_window (
      .clk     (clk),
      .rst_n   (rst_n),
      .shift_i (cyc_start),
      .clear_i (~ss_done),
      .bit_i   (cyc_event),
      .req_o   (sd_req)
   );

   // R4: a request only follows a cycle-start clock with soft-start done.
   p_req_on_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
      sd_req |-> ($past(cyc_start) && $past(ss_done)));

   // R5: a request needs a non-zero code two clocks earlier.
   p_zero_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
      sd_req |-> ($past(sc_code, 2) != '0));

endmodule

// File: tb/test_sc_short_detect.sv
`timescale 1ns/1ps
module test_sc_short_detect;

   localparam int RW   = 6;
   localparam int CW   = 4;
   localparam int RMAX = 40;
   localparam int WIN  = 32;
   localparam int LIM  = 8;
   localparam int CLEN = 48;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cyc_start = 1'b0;
   logic [RW-1:0] ramp = '0;
   logic [CW-1:0] sc_code = '0;
   logic          oc_flag = 1'b0;
   logic          ss_done = 1'b0;
   logic          sd_req;

   int  n_checks = 0;
   int  n_fail   = 0;
   int  req_seen = 0;
   bit  cmp_on   = 1'b0;
   bit  done     = 1'b0;
   string phase  = "R9";

   // Reference model state
   bit  mq[$];
   bit  m_ev, m_cross, exp_req;

   always #5 clk = ~clk;

   sc_short_detect #(
      .RAMP_W (RW), .CODE_W (CW), .RAMP_MAX (RMAX),
      .WIN_LEN (WIN), .EVT_LIMIT (LIM)
   ) i_sc_short_detect (
      .clk (clk), .rst_n (rst_n), .cyc_start (cyc_start), .ramp (ramp),
      .sc_code (sc_code), .oc_flag (oc_flag), .ss_done (ss_done),
      .sd_req (sd_req)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   // Behavioural model of the requirements, updated at each rising edge.
   always @(posedge clk) begin
      if (!rst_n) begin
         mq.delete(); m_ev = 0; m_cross = 0; exp_req = 0;
      end else begin
         int thr_v;
         int sum;
         bit en;
         thr_v = (int'(sc_code) * RMAX) / (1 << CW);
         en = ss_done && (sc_code != 0);
         exp_req = 0;
         if (!ss_done) begin
            mq.delete();
         end else if (cyc_start) begin
            mq.push_back(m_ev);
            if (mq.size() > WIN) void'(mq.pop_front());
            sum = 0;
            foreach (mq[i]) sum += int'(mq[i]);
            if (sum >= LIM) begin
               exp_req = 1;
               mq.delete();
            end
         end
         if (cyc_start) begin
            m_cross = 0; m_ev = 0;
         end
         if (int'(ramp) >= thr_v) m_cross = 1;
         if (!en) m_ev = 0;
         else if (oc_flag && !m_cross) m_ev = 1;
      end
   end

   always @(negedge clk) begin
      if (cmp_on) chk(sd_req == exp_req, {phase, " per-clock"}, int'(sd_req), int'(exp_req));
      if (sd_req) req_seen++;
   end

   task automatic run_cycle(input int lo, input int hi);
      for (int r = 0; r < CLEN; r++) begin
         @(negedge clk);
         cyc_start = (r == 0);
         ramp      = RW'((r > RMAX) ? RMAX : r);
         oc_flag   = (r >= lo) && (r <= hi);
      end
   endtask

   task automatic run_n(input int n, input int lo, input int hi);
      for (int k = 0; k < n; k++) run_cycle(lo, hi);
   endtask

   task automatic start_scn(input string tag, input int code);
      @(negedge clk);
      phase = tag; ss_done = 0; cyc_start = 0; oc_flag = 0; ramp = '0;
      sc_code = CW'(code);
      @(negedge clk);
      ss_done = 1;
      req_seen = 0;
   endtask

   task automatic end_scn(input string tag, input int exp);
      run_cycle(1, 0);
      @(negedge clk);
      chk(req_seen == exp, {tag, " request count"}, req_seen, exp);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      cmp_on = 1;
      @(negedge clk);
      chk(sd_req == 1'b0, "R9 reset state", int'(sd_req), 0);

      // R1: overcurrent one count below the threshold (20) counts.
      start_scn("R1", 8); run_n(8, 19, 19); end_scn("R1", 1);
      // R2: overcurrent exactly at the threshold does not count.
      start_scn("R2", 8); run_n(9, 20, 20); end_scn("R2", 0);
      // R2: late overcurrent well after crossing.
      start_scn("R2", 8); run_n(12, 25, 35); end_scn("R2", 0);
      // R3: many overcurrent clocks per cycle give one event each.
      start_scn("R3", 8); run_n(7, 2, 10); end_scn("R3", 0);
      req_seen = 0; run_n(1, 2, 10); end_scn("R3", 1);
      // R5: zero code disables detection.
      start_scn("R5", 0); run_n(12, 0, 47); end_scn("R5", 0);
      // R6: soft-start not done records nothing.
      start_scn("R6", 8); ss_done = 0; run_n(12, 0, 5); ss_done = 1; end_scn("R6", 0);
      // R6: a soft-start restart discards history.
      start_scn("R6", 8); run_n(7, 3, 3);
      @(negedge clk); ss_done = 0; @(negedge clk); ss_done = 1;
      run_n(7, 3, 3); end_scn("R6", 0);
      // R4 and R7: two requests from sixteen events; history cleared between.
      start_scn("R7", 8); run_n(16, 5, 5); end_scn("R7", 2);
      // R8: oldest event one cycle past the window no longer counts.
      start_scn("R8", 8); run_n(7, 4, 4); run_n(25, 1, 0); run_n(1, 4, 4); end_scn("R8", 0);
      // R8: same pattern with the oldest event just inside the window.
      start_scn("R8", 8); run_n(7, 4, 4); run_n(24, 1, 0); run_n(1, 4, 4); end_scn("R8", 1);
      // R4: high code places threshold near max duty (15*40/16 = 37).
      start_scn("R4", 15); run_n(8, 36, 36); end_scn("R4", 1);

      done = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog expired in phase %s actual=0 expected=1", phase);
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

endmodule